// File: doc/BRIEF.md
# Two-Wire Serial Memory Target, 2 KiB

This block is the target side of a two-wire (I2C) bus, presenting 2048 bytes of on-chip storage the way a small serial EEPROM would. It watches the clock and data lines with the system clock, finds START and STOP conditions, and moves bytes in and out through an open-drain data driver. The line logic ANDs the block's pull-down with the other drivers on the bus.

The 11-bit memory address is split across two bytes. The three high bits ride in the select byte, beside a fixed four-bit identifier and the direction flag. The low eight bits follow as the first byte of a write. A write that ends there only sets the pointer. A repeated START with the direction flag set then reads from that spot. Written data advances the pointer inside its 16-byte page. Read data advances it across the whole array.

Top module: `ee2k_target`

## Requirements
- R1: A select byte whose bits 7:4 equal 1010 is acknowledged: the block pulls SDA low for the ninth clock of that byte. Bits 3:1 become memory address bits 10:8, and bit 0 picks the direction (0 write, 1 read).
- R2: A select byte with any other value in bits 7:4 is not acknowledged. SDA is never pulled low from then until the next START, and the bytes clocked in that time change no stored data.
- R3: In a write, the byte after the select byte sets address bits 7:0 and is acknowledged. Every later byte is stored at the pointer and acknowledged.
- R4: After each stored byte only pointer bits 3:0 advance, so a write that runs past the end of a 16-byte page wraps to that page's first byte. Bytes outside the page are left unchanged.
- R5: A write carrying only the address, followed by a repeated START and a read-direction select byte, returns data starting at that address.
- R6: During a read, each byte the master acknowledges moves the pointer by one across all 11 bits, wrapping from 0x7FF to 0x000. The next byte is sent from there.
- R7: After the master leaves a read byte unacknowledged, the block releases SDA and stays silent until the next START.
- R8: A STOP condition releases SDA and returns the block to idle.
- R9: While reset is asserted and right after it, SDA is released.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A bad bit counter or a stale state shows up at the pins within one byte. An acknowledge lands on the wrong clock, or the block keeps pulling SDA low after a NACK, a mismatched identifier or a STOP. Pointer faults show up later, at the next read of the affected addresses. Data sits at the wrong place in the page after a wrap, or the read sequence does not come back to address zero. For that reason the bench reads back every area it writes, including the byte just past a wrapped page.

// File: rtl/ee2k_pkg.sv
package ee2k_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_LOADDR,
    ST_LOADDR_ACK,
    ST_WBYTE,
    ST_WBYTE_ACK,
    ST_RBYTE,
    ST_RBYTE_ACK
  } ee_state_t;
endpackage

// File: rtl/ee2k_line_sync.sv
module ee2k_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_p_q, scl_p_d, sda_p_q, sda_p_d;
  logic scl_h_q, sda_h_q;
  logic scl_s;

  always_comb begin
    scl_p_d = {scl_p_q[STAGES-2:0], scl_i};
    sda_p_d = {sda_p_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= '1;
      sda_p_q <= '1;
      scl_h_q <= 1'b1;
      sda_h_q <= 1'b1;
    end else begin
      scl_p_q <= scl_p_d;
      sda_p_q <= sda_p_d;
      scl_h_q <= scl_s;
      sda_h_q <= sda_s;
    end
  end

  assign scl_s     = scl_p_q[STAGES-1];
  assign sda_s     = sda_p_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_h_q;
  assign scl_fall  = ~scl_s & scl_h_q;
  assign bus_start = scl_s & scl_h_q & sda_h_q & ~sda_s;
  assign bus_stop  = scl_s & scl_h_q & ~sda_h_q & sda_s;
endmodule

// File: rtl/ee2k_store.sv
module ee2k_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) cell_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_q <= cell_q[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ee2k_ctrl.sv
module ee2k_ctrl
  import ee2k_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter int          PAGE_W = 4,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe,
  output ee_state_t         state_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - 8;

  ee_state_t         st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [7:0]        tx_q, tx_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    oe_d   = oe_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    mem_we = 1'b0;
    if (bus_start) begin
      st_d  = ST_SEL;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (bus_stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_SEL, ST_LOADDR, ST_WBYTE: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            case (st_q)
              ST_SEL: begin
                if (sh_q[7:4] == DEV_ID) begin
                  oe_d                = 1'b1;
                  rw_d                = sh_q[0];
                  ptr_d[ADDR_W-1:8]   = sh_q[HI_W:1];
                  st_d                = ST_SEL_ACK;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              ST_LOADDR: begin
                ptr_d[7:0] = sh_q;
                oe_d       = 1'b1;
                st_d       = ST_LOADDR_ACK;
              end
              default: begin
                mem_we              = 1'b1;
                ptr_d[PAGE_W-1:0]   = ptr_q[PAGE_W-1:0] + 1'b1;
                oe_d                = 1'b1;
                st_d                = ST_WBYTE_ACK;
              end
            endcase
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              tx_d = rd_data;
              oe_d = ~rd_data[7];
              st_d = ST_RBYTE;
            end else begin
              oe_d = 1'b0;
              st_d = ST_LOADDR;
            end
          end
        end
        ST_LOADDR_ACK, ST_WBYTE_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = 4'd0;
            st_d  = ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = ST_RBYTE_ACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_RBYTE_ACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
            if (!sda_s) ptr_d = ptr_q + 1'b1;
          end else if (scl_fall) begin
            if (!mack_q) begin
              tx_d  = rd_data;
              oe_d  = ~rd_data[7];
              cnt_d = 4'd0;
              st_d  = ST_RBYTE;
            end else begin
              oe_d = 1'b0;
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
    end
  end

  assign mem_addr  = ptr_q;
  assign mem_wdata = sh_q;
  assign sda_oe    = oe_q;
  assign state_o   = st_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/ee2k_target.sv
module ee2k_target
  import ee2k_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, rd_data;
  ee_state_t         ctrl_state;
  logic [ADDR_W-1:0] ctrl_ptr;

  ee2k_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  ee2k_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe),
    .state_o   (ctrl_state),
    .ptr_o     (ctrl_ptr)
  );

  ee2k_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (mem_addr),
    .wr_data (mem_wdata),
    .rd_addr (mem_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ee2k_target_chk.sv
module ee2k_target_chk
  import ee2k_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              bus_stop,
  input logic              mem_we,
  input ee_state_t         ctrl_state,
  input logic [ADDR_W-1:0] ctrl_ptr
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == ST_IDLE) |-> !sda_oe);

  p_store_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);

  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ctrl_ptr[ADDR_W-1:PAGE_W] == $past(ctrl_ptr[ADDR_W-1:PAGE_W])) &&
               (ctrl_ptr[PAGE_W-1:0] == $past(ctrl_ptr[PAGE_W-1:0]) + 1'b1));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe && (ctrl_state == ST_IDLE));

  p_scl_low_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind ee2k_target ee2k_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe     (sda_oe),
  .bus_stop   (bus_stop),
  .mem_we     (mem_we),
  .ctrl_state (ctrl_state),
  .ctrl_ptr   (ctrl_ptr)
);

// File: tb/test_ee2k_target.sv
module test_ee2k_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  ee2k_target i_ee2k_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] refm [0:2047];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];
  bit oe_seen = 1'b0;
  int r10_viol = 0;
  logic oe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs each read byte with the expected one
  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g === e, t, g, e);
    end
  end

  always @(negedge clk) begin
    if (sda_oe) oe_seen = 1'b1;
    if (rst_n && sda_oe !== oe_prev && m_scl) r10_viol++;
    oe_prev = sda_oe;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(2 * Q);
  endtask

  task automatic clk_bit(input logic drv, output logic samp);
    m_sda = drv; hold(Q);
    m_scl = 1'b1; hold(Q);
    samp = sda_line; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  task automatic page_write(input logic [10:0] a, input logic [7:0] d [$]);
    bit ack;
    b_start();
    wr_byte({4'b1010, a[10:8], 1'b0}, ack);
    chk(ack, "R1 select ack", ack, 1);
    wr_byte(a[7:0], ack);
    chk(ack, "R3 address ack", ack, 1);
    foreach (d[i]) begin
      wr_byte(d[i], ack);
      chk(ack, "R3 data ack", ack, 1);
      refm[{a[10:4], 4'(a[3:0] + i)}] = d[i];
    end
    b_stop();
  endtask

  task automatic seq_read(input logic [10:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    b_start();
    wr_byte({4'b1010, a[10:8], 1'b0}, ack);
    chk(ack, "R1 select ack", ack, 1);
    wr_byte(a[7:0], ack);
    chk(ack, "R3 address ack", ack, 1);
    b_start();
    wr_byte({4'b1010, a[10:8], 1'b1}, ack);
    chk(ack, "R5 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(refm[11'(a + i)]);
      tag_q.push_back(tag);
      rd_byte(i < n - 1, b);
      got_q.push_back(b);
    end
    b_stop();
  endtask

  initial begin
    hold(200_000 - 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic s;
    hold(5);
    chk(sda_oe === 1'b0, "R9 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    hold(5);
    chk(sda_oe === 1'b0, "R9 released after reset", sda_oe, 0);

    page_write(11'h123, '{8'h5A});
    chk(sda_oe === 1'b0, "R8 released after stop", sda_oe, 0);
    seq_read(11'h123, 1, "R5 random read");

    page_write(11'h360, '{8'hEE});
    page_write(11'h35C, '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15});
    seq_read(11'h35C, 4, "R4 page tail");
    seq_read(11'h350, 2, "R4 page wrap");
    seq_read(11'h360, 1, "R4 next page intact");

    page_write(11'h7FE, '{8'hA1, 8'hA2});
    page_write(11'h000, '{8'hB1, 8'hB2});
    seq_read(11'h7FE, 4, "R6 wrap to zero");

    // R7: NACK ends the read; further clocks see no drive
    b_start();
    wr_byte(8'hAE, ack);
    wr_byte(8'hFE, ack);
    b_start();
    wr_byte(8'hAF, ack);
    exp_q.push_back(refm[11'h7FE]);
    tag_q.push_back("R7 last byte");
    rd_byte(1'b0, b);
    got_q.push_back(b);
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
    chk(oe_seen == 1'b0, "R7 silent after nack", oe_seen, 0);
    b_stop();

    // R2: foreign identifier
    oe_seen = 1'b0;
    b_start();
    wr_byte(8'hB2, ack);
    chk(ack == 1'b0, "R2 foreign id nack", ack, 0);
    wr_byte(8'h23, ack);
    wr_byte(8'h99, ack);
    chk(oe_seen == 1'b0, "R2 no drive", oe_seen, 0);
    b_stop();
    seq_read(11'h123, 1, "R2 data unchanged");

    hold(20);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    chk(r10_viol == 0, "R10 drive changes only with SCL low", r10_viol, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule